// File: doc/BRIEF.md
# Successive-Approximation Sequencer with Two-Order Serial Output

This block sequences one conversion of a successive-approximation converter and serializes the result. An upstream address receiver pulses `start` once the channel assignment has been shifted in. The sequencer then waits half a serial clock for sampling and raises `busy`. It presents a trial code to an external DAC and comparator and resolves one bit per serial clock period, from the most significant bit down.

Each decision appears on the serial output at the falling edge on which it is taken, so a host can read the result MSB-first while the conversion runs. After the last decision the stored result is sent a second time, least significant bit first. The LSB is shared between the two streams and is not sent twice. A build parameter picks how that second stream behaves: it can be left out, so the LSB is held; it can run on its own; or it can be paced by a shift-enable input.

The serial clock is not used as a clock. The block runs on a fast system clock and receives single-cycle `sclk_rise` and `sclk_fall` strobes. Chip select is active low. Driving it high clears the sequence at any point and releases the output.

Top module: `sar_sequencer`

## Requirements
- R1: After reset, and whenever `cs_n` is high, `busy`, `sdo_oe`, `sdo` and `trial_code` are all zero.
- R2: `start` is accepted only in a cycle with `sclk_rise` high, `cs_n` low and no conversion under way since chip select fell. `busy` rises on the clock after the next `sclk_fall` strobe. Pulses at any other time have no effect.
- R3: In the cycle `busy` rises, `sdo_oe` goes high and `sdo` drives a leading 0.
- R4: `trial_code` is 1 followed by zeros once `start` is accepted. At each decision strobe, the bit under trial takes the value of `cmp_hi` (1 keeps it, 0 clears it) and the next lower bit is set. After the eighth decision `trial_code` equals the result, and it holds that value until `cs_n` rises.
- R5: The 8 falling strobes after the one that raised `busy` each drive the new decision onto `sdo`, bit 7 first and bit 0 last.
- R6: `busy` falls on the first `sclk_rise` strobe after the eighth decision.
- R7: With `ORDER = ORDER_AUTO_LSB`, every falling strobe after `busy` falls sends the next result bit, bit 1 through bit 7, after the shared bit 0. From then on `sdo` is 0 until `cs_n` rises.
- R8: With `ORDER = ORDER_SHIFT_GATED`, a falling strobe while `shift_en` is high leaves `sdo` unchanged. A falling strobe while it is low advances the stream as in R7.
- R9: With `ORDER = ORDER_MSB_ONLY`, `sdo` keeps bit 0 after `busy` falls until `cs_n` rises. `shift_en` has no effect.
- R10: If the comparator never reports high, as when the positive input is below the negative one, the result and the whole stream are zeros.
- R11: `cs_n` high in any phase clears `busy`, `sdo_oe` and `trial_code` on the next clock. After chip select falls again, nothing happens until a fresh `start`.
- R12: While `sdo_oe` is low, `sdo` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low; high aborts and clears |
| sclk_rise | input | 1 | One-cycle strobe for a serial clock rising edge |
| sclk_fall | input | 1 | One-cycle strobe for a serial clock falling edge |
| start | input | 1 | Assignment complete from the address receiver |
| cmp_hi | input | 1 | Comparator: input at or above the trial level |
| shift_en | input | 1 | LSB-first pacing (gated variant only), high holds |
| trial_code | output | WIDTH | Trial code to the DAC |
| sdo | output | 1 | Serial data output |
| sdo_oe | output | 1 | Output enable for `sdo` (low means high impedance) |
| busy | output | 1 | Conversion in progress |

## Verification
The bench closes the loop with a behavioural comparator against an integer input level. It runs the three output variants side by side. Inputs include the top code, an over-range level, a negative level, a level of one, mid-scale and mixed bit patterns. These catch a design that loses or doubles the shared LSB, shows bit 1 one strobe early, or lets `busy` fall on a falling edge instead of the rise half a period later. Irregular `shift_en` patterns expose a gated stream that shifts while held or that disturbs the other variants. Starts that arrive off the rising strobe, with chip select high, or in the middle of a conversion, together with a mid-conversion abort and a reselection with no new start, catch a design that relaunches or keeps stale state.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

   // How the stored result is replayed once the MSB-first stream has ended
   typedef enum logic [1:0] {
      ORDER_MSB_ONLY    = 2'd0,
      ORDER_AUTO_LSB    = 2'd1,
      ORDER_SHIFT_GATED = 2'd2
   } order_mode_e;

   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_SAMPLE = 3'd1,
      PH_CONV   = 3'd2,
      PH_TAIL   = 3'd3,
      PH_SERIAL = 3'd4
   } phase_e;

endpackage

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
   import sar_seq_pkg::*;
#(
   parameter int WIDTH = 8,
   localparam int IDXW = (WIDTH > 1) ? $clog2(WIDTH) : 1
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cs_n,
   input  logic            sclk_rise,
   input  logic            sclk_fall,
   input  logic            start,
   output logic            arm_o,
   output logic            launch_o,
   output logic            decide_o,
   output logic [IDXW-1:0] idx_o,
   output logic            serial_o,
   output logic            busy_o
);

   localparam logic [IDXW-1:0] IDX_TOP = IDXW'(WIDTH - 1);

   phase_e          phase_q;
   logic [IDXW-1:0] idx_q;
   logic            busy_q;
   logic            release_w;

   always_comb begin
      arm_o     = !cs_n && (phase_q == PH_IDLE)   && sclk_rise && start;
      launch_o  = !cs_n && (phase_q == PH_SAMPLE) && sclk_fall;
      decide_o  = !cs_n && (phase_q == PH_CONV)   && sclk_fall;
      release_w = !cs_n && (phase_q == PH_TAIL)   && sclk_rise;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         idx_q   <= '0;
         busy_q  <= 1'b0;
      end else if (cs_n) begin
         phase_q <= PH_IDLE;
         idx_q   <= '0;
         busy_q  <= 1'b0;
      end else begin
         case (phase_q)
            PH_IDLE:   if (arm_o) phase_q <= PH_SAMPLE;
            PH_SAMPLE: if (launch_o) begin
               phase_q <= PH_CONV;
               idx_q   <= IDX_TOP;
               busy_q  <= 1'b1;
            end
            PH_CONV:   if (decide_o) begin
               if (idx_q == '0) phase_q <= PH_TAIL;
               else             idx_q   <= idx_q - 1'b1;
            end
            PH_TAIL:   if (release_w) begin
               phase_q <= PH_SERIAL;
               busy_q  <= 1'b0;
            end
            PH_SERIAL: phase_q <= PH_SERIAL;
            default:   phase_q <= PH_IDLE;
         endcase
      end
   end

   assign idx_o    = idx_q;
   assign serial_o = (phase_q == PH_SERIAL);
   assign busy_o   = busy_q;

   // R2: status only rises on a falling strobe while selected
   a_r2_busy_rise_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> ($past(sclk_fall) && !$past(cs_n)));

   // R6: status only drops on a rising strobe or an abort
   a_r6_busy_fall_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> ($past(sclk_rise) || $past(cs_n)));

   // R11: deselect clears status on the next clock
   a_r11_abort_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> !busy_q);

endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
   parameter int WIDTH = 8,
   localparam int IDXW = (WIDTH > 1) ? $clog2(WIDTH) : 1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             arm_i,
   input  logic             decide_i,
   input  logic [IDXW-1:0]  idx_i,
   input  logic             cmp_hi,
   output logic [WIDTH-1:0] trial_o
);

   localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

   logic [WIDTH-1:0] trial_q;
   logic [WIDTH-1:0] trial_nxt;

   always_comb begin
      trial_nxt = trial_q;
      if (arm_i) begin
         trial_nxt = TOP_BIT;
      end else if (decide_i) begin
         for (int b = 0; b < WIDTH; b++) begin
            if (b == int'(idx_i))          trial_nxt[b] = cmp_hi;
            else if (b + 1 == int'(idx_i)) trial_nxt[b] = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     trial_q <= '0;
      else if (clr_i) trial_q <= '0;
      else            trial_q <= trial_nxt;
   end

   assign trial_o = trial_q;

   // R4: a decision touches only the bit under trial and the one below it
   a_r4_two_bits_per_step: assert property (@(posedge clk) disable iff (!rst_n)
      decide_i |=> ($countones(trial_q ^ $past(trial_q)) <= 2));

   // R4: the result is frozen outside the arm/decide strobes
   a_r4_hold_between_steps: assert property (@(posedge clk) disable iff (!rst_n)
      (!arm_i && !decide_i && !clr_i) |=> $stable(trial_q));

endmodule

// File: rtl/sar_out_serializer.sv
module sar_out_serializer
   import sar_seq_pkg::*;
#(
   parameter int          WIDTH = 8,
   parameter order_mode_e ORDER = ORDER_AUTO_LSB
)(
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic launch_i,
   input  logic decide_i,
   input  logic cmp_hi,
   input  logic serial_i,
   input  logic sclk_fall,
   input  logic shift_en,
   output logic sdo_o,
   output logic sdo_oe_o
);

   logic [WIDTH-1:0] sr_q;
   logic             sdo_q;
   logic             oe_q;
   logic             step_ok;

   generate
      if (ORDER == ORDER_MSB_ONLY) begin : g_msb_only
         logic shift_en_unused;
         assign shift_en_unused = shift_en;
         assign step_ok = 1'b0;
      end else if (ORDER == ORDER_AUTO_LSB) begin : g_auto
         logic shift_en_unused;
         assign shift_en_unused = shift_en;
         assign step_ok = 1'b1;
      end else begin : g_gated
         assign step_ok = !shift_en;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q  <= '0;
         sdo_q <= 1'b0;
         oe_q  <= 1'b0;
      end else if (clr_i) begin
         sr_q  <= '0;
         sdo_q <= 1'b0;
         oe_q  <= 1'b0;
      end else if (launch_i) begin
         sr_q  <= '0;
         sdo_q <= 1'b0;
         oe_q  <= 1'b1;
      end else if (decide_i) begin
         sr_q  <= {sr_q[WIDTH-2:0], cmp_hi};
         sdo_q <= cmp_hi;
      end else if (serial_i && sclk_fall && step_ok) begin
         // bit 0 is already on the pin; replay upward, zeros fill behind
         sdo_q <= sr_q[1];
         sr_q  <= {1'b0, sr_q[WIDTH-1:1]};
      end
   end

   assign sdo_o    = sdo_q;
   assign sdo_oe_o = oe_q;

   // R3: conversion start enables the pin with a leading zero
   a_r3_lead_zero: assert property (@(posedge clk) disable iff (!rst_n)
      launch_i |=> (oe_q && !sdo_q));

   // R11: deselect releases the pin on the next clock
   a_r11_release_pin: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> !oe_q);

   // R12: data is quiet while the pin is released
   a_r12_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_q |-> !sdo_q);

   generate
      if (ORDER == ORDER_MSB_ONLY) begin : g_chk_msb
         // R9: the LSB is held for as long as the device stays selected
         a_r9_lsb_held: assert property (@(posedge clk) disable iff (!rst_n)
            (serial_i && $past(serial_i)) |-> $stable(sdo_q));
      end
   endgenerate

endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer
   import sar_seq_pkg::*;
#(
   parameter int          WIDTH = 8,
   parameter order_mode_e ORDER = ORDER_AUTO_LSB,
   localparam int         IDXW  = (WIDTH > 1) ? $clog2(WIDTH) : 1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n,
   input  logic             sclk_rise,
   input  logic             sclk_fall,
   input  logic             start,
   input  logic             cmp_hi,
   input  logic             shift_en,
   output logic [WIDTH-1:0] trial_code,
   output logic             sdo,
   output logic             sdo_oe,
   output logic             busy
);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("sar_sequencer: WIDTH must be at least 2");
      end
      if (ORDER != ORDER_MSB_ONLY && ORDER != ORDER_AUTO_LSB &&
          ORDER != ORDER_SHIFT_GATED) begin : g_bad_order
         $error("sar_sequencer: unknown ORDER");
      end
   endgenerate

   logic            arm_w;
   logic            launch_w;
   logic            decide_w;
   logic [IDXW-1:0] idx_w;
   logic            serial_w;

   sar_seq_ctrl #(.WIDTH(WIDTH)) i_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_n      (cs_n),
      .sclk_rise (sclk_rise),
      .sclk_fall (sclk_fall),
      .start     (start),
      .arm_o     (arm_w),
      .launch_o  (launch_w),
      .decide_o  (decide_w),
      .idx_o     (idx_w),
      .serial_o  (serial_w),
      .busy_o    (busy)
   );

   sar_trial_reg #(.WIDTH(WIDTH)) i_trial (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (cs_n),
      .arm_i    (arm_w),
      .decide_i (decide_w),
      .idx_i    (idx_w),
      .cmp_hi   (cmp_hi),
      .trial_o  (trial_code)
   );

   sar_out_serializer #(.WIDTH(WIDTH), .ORDER(ORDER)) i_ser (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (cs_n),
      .launch_i  (launch_w),
      .decide_i  (decide_w),
      .cmp_hi    (cmp_hi),
      .serial_i  (serial_w),
      .sclk_fall (sclk_fall),
      .shift_en  (shift_en),
      .sdo_o     (sdo),
      .sdo_oe_o  (sdo_oe)
   );

endmodule

// File: tb/test_sar_sequencer.sv
module test_sar_sequencer;
   import sar_seq_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int SDIV       = 8;
   localparam int W          = 8;
   localparam int NINST      = 3;  // 0 msb-only, 1 auto, 2 gated

   logic clk = 1'b0;
   logic rst_n, cs_n, sclk_rise, sclk_fall, start, shift_en;
   logic [W-1:0] trial_w [NINST];
   logic sdo_w [NINST];
   logic oe_w [NINST];
   logic busy_w [NINST];
   logic cmp_w [NINST];

   integer vin = 0;
   integer ph = 0;
   bit start_req = 0, skew_req = 0, finished = 0;
   integer n_checks = 0, n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   for (genvar m = 0; m < NINST; m++) begin : g_cmp
      assign cmp_w[m] = (vin >= int'(trial_w[m]));
   end

   sar_sequencer #(.WIDTH(W), .ORDER(ORDER_MSB_ONLY)) i_sar_sequencer_msb (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
      .start(start), .cmp_hi(cmp_w[0]), .shift_en(shift_en), .trial_code(trial_w[0]),
      .sdo(sdo_w[0]), .sdo_oe(oe_w[0]), .busy(busy_w[0]));
   sar_sequencer #(.WIDTH(W), .ORDER(ORDER_AUTO_LSB)) i_sar_sequencer (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
      .start(start), .cmp_hi(cmp_w[1]), .shift_en(shift_en), .trial_code(trial_w[1]),
      .sdo(sdo_w[1]), .sdo_oe(oe_w[1]), .busy(busy_w[1]));
   sar_sequencer #(.WIDTH(W), .ORDER(ORDER_SHIFT_GATED)) i_sar_sequencer_gated (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
      .start(start), .cmp_hi(cmp_w[2]), .shift_en(shift_en), .trial_code(trial_w[2]),
      .sdo(sdo_w[2]), .sdo_oe(oe_w[2]), .busy(busy_w[2]));

   task automatic chk(input string tag, input string what, input integer act, input integer exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   // serial clock strobes and start injection, all at the falling system edge
   always @(negedge clk) begin
      ph = (ph + 1) % SDIV;
      sclk_rise = (ph == 0);
      sclk_fall = (ph == SDIV/2);
      start = 1'b0;
      if (start_req && ph == 0) begin start = 1'b1; start_req = 0; end
      if (skew_req && ph == 2)  begin start = 1'b1; skew_req = 0; end
   end

   function automatic integer clip(input integer v);
      return (v < 0) ? 0 : ((v > 255) ? 255 : v);
   endfunction

   // reference model: phase numbers and event counts
   integer st [NINST], k [NINST], s [NINST];
   integer e_busy [NINST], e_oe [NINST], e_sdo [NINST], e_trial [NINST];

   always @(posedge clk) begin
      for (int m = 0; m < NINST; m++) begin
         integer res, b;
         res = clip(vin);
         if (!rst_n || cs_n) begin
            st[m] = 0; k[m] = 0; s[m] = 0;
            e_busy[m] = 0; e_oe[m] = 0; e_sdo[m] = 0; e_trial[m] = 0;
         end else begin
            case (st[m])
               0: if (sclk_rise && start) begin st[m] = 1; e_trial[m] = 128; end
               1: if (sclk_fall) begin
                     st[m] = 2; k[m] = 0; e_busy[m] = 1; e_oe[m] = 1; e_sdo[m] = 0;
                  end
               2: if (sclk_fall) begin
                     k[m] = k[m] + 1;
                     b = 8 - k[m];
                     e_sdo[m] = (res >> b) & 1;
                     e_trial[m] = (res & (255 & ~((1 << b) - 1))) | ((b > 0) ? (1 << (b - 1)) : 0);
                     if (k[m] == 8) st[m] = 3;
                  end
               3: if (sclk_rise) begin st[m] = 4; e_busy[m] = 0; s[m] = 0; end
               default: if (sclk_fall && (m == 1 || (m == 2 && !shift_en))) begin
                     s[m] = s[m] + 1;
                     e_sdo[m] = (s[m] < 8) ? ((res >> s[m]) & 1) : 0;
                  end
            endcase
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         for (int m = 0; m < NINST; m++) begin
            string tsdo;
            if (st[m] <= 1)                  tsdo = "R12";
            else if (st[m] == 2)             tsdo = (k[m] == 0) ? "R3" : "R5";
            else if (st[m] == 3)             tsdo = "R5";
            else if (m == 0)                 tsdo = "R9";
            else if (m == 1)                 tsdo = "R7";
            else                             tsdo = "R8";
            chk("R3", "sdo_oe", int'(oe_w[m]), e_oe[m]);
            chk("R6", "busy", int'(busy_w[m]), e_busy[m]);
            chk((st[m] == 0) ? "R11" : "R4", "trial_code", int'(trial_w[m]), e_trial[m]);
            chk(tsdo, "sdo", int'(sdo_w[m]), e_sdo[m]);
         end
      end
   end

   task automatic wait_periods(input int n);
      repeat (n * SDIV) @(negedge clk);
   endtask

   task automatic request_start();
      @(posedge clk);
      start_req = 1;
   endtask

   task automatic run_conv(input integer v, input logic [15:0] pattern);
      vin = v;
      shift_en = 1'b1;
      wait_periods(1);
      cs_n = 1'b0;
      wait_periods(1);
      request_start();
      wait_periods(3);
      request_start();       // R2: arrives mid-conversion, must be ignored
      wait_periods(8);
      for (int i = 0; i < 16; i++) begin
         shift_en = pattern[i];
         wait_periods(1);
      end
      for (int m = 0; m < NINST; m++)
         chk((v < 0) ? "R10" : "R4", "final trial_code", int'(trial_w[m]), clip(v));
      chk("R7", "auto stream ends low", int'(sdo_w[1]), 0);
      chk("R9", "msb-only holds bit 0", int'(sdo_w[0]), clip(v) & 1);
      cs_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      for (int m = 0; m < NINST; m++) begin
         chk("R11", "deselect releases pin", int'(oe_w[m]), 0);
         chk("R11", "deselect clears busy", int'(busy_w[m]), 0);
      end
   endtask

   initial begin
      rst_n = 1'b0; cs_n = 1'b1; shift_en = 1'b1;
      sclk_rise = 1'b0; sclk_fall = 1'b0; start = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      for (int m = 0; m < NINST; m++) begin
         chk("R1", "reset busy", int'(busy_w[m]), 0);
         chk("R1", "reset sdo_oe", int'(oe_w[m]), 0);
         chk("R1", "reset trial_code", int'(trial_w[m]), 0);
      end

      // R2: start while deselected, then start off the rising strobe
      request_start();
      wait_periods(3);
      for (int m = 0; m < NINST; m++) chk("R2", "start while deselected", int'(busy_w[m]), 0);
      cs_n = 1'b0;
      @(posedge clk);
      skew_req = 1;
      wait_periods(3);
      for (int m = 0; m < NINST; m++) chk("R2", "start off rising strobe", int'(busy_w[m]), 0);
      cs_n = 1'b1;

      run_conv(165, 16'b0110_0101_1100_0111);
      run_conv(255, 16'h0000);
      run_conv(0,   16'hA5A5);
      run_conv(-20, 16'h0F0F);   // R10: negative input gives zeros
      run_conv(1,   16'b0000_0000_0000_0001);
      run_conv(128, 16'hFFF0);
      run_conv(300, 16'h3333);
      run_conv(90,  16'b1001_0110_0101_1010);

      // R11: abort in the middle of a conversion, then reselect with no start
      vin = 200;
      wait_periods(1);
      cs_n = 1'b0;
      wait_periods(1);
      request_start();
      wait_periods(4);
      for (int m = 0; m < NINST; m++) chk("R11", "converting before abort", int'(busy_w[m]), 1);
      cs_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      for (int m = 0; m < NINST; m++) begin
         chk("R11", "abort clears busy", int'(busy_w[m]), 0);
         chk("R11", "abort releases pin", int'(oe_w[m]), 0);
         chk("R11", "abort clears trial", int'(trial_w[m]), 0);
      end
      wait_periods(1);
      cs_n = 1'b0;
      wait_periods(12);
      for (int m = 0; m < NINST; m++) chk("R11", "no restart without start", int'(busy_w[m]), 0);
      cs_n = 1'b1;
      wait_periods(1);

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         finished = 1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

endmodule